// File: doc/BRIEF.md
# 64-bit Interval Timer

This peripheral counts from zero up to a programmable 64-bit limit, wraps back to zero on reaching it and flags the event through a status bit and a level interrupt. Software drives it through a plain 32-bit register port with a single-cycle read and write strobe. The counter advances either from the bus clock or from a slower external clock. The slower clock is brought in through a two-flop synchroniser, and each of its rising edges becomes one source tick. The selected source then passes through a 4-bit prescaler.

Two operating styles are supported. In periodic mode the counter keeps wrapping, which suits a steady tick. In one-shot mode it stops after the first wrap, which suits a single programmed delay. The limit register is 64 bits wide and is loaded through two word writes. Writing the high word first and the low word second makes the new limit take effect in a single step. The running count can be read without tearing: a read of the low word freezes a copy of the high word, and the next high-word read returns that copy.

Top module: `itimer64`

## Requirements
- R1: After reset the counter is 0 and stopped, the status, interrupt enable and mode are 0, the limit is all ones, and `irq` is low.
- R2: A write to control (offset 0x00) with bit 0 set starts counting. A write with bit 8 set stops the timer and clears the counter, the pending status and the prescaler phase. When both bits are set in one write, bit 8 wins and the timer stays stopped.
- R3: A write to the high limit word (0x0C) is only staged. The next write to the low limit word (0x08) loads the staged high word and the new low word together as the active limit. Reads of 0x08 and 0x0C return the active limit.
- R4: On a count step where the counter equals the limit, the counter goes to 0 and status bit 0 is set. If mode bit 0 is 1 (periodic), counting continues. If it is 0 (one-shot), counting halts with the counter at 0 until the next start.
- R5: Mode bits 11:8 hold a value p, and the counter steps once every p+1 source ticks. The mode register (0x04) reads back bits 0, 3 and 11:8.
- R6: When mode bit 3 is 1, the source is the slow clock input. A rising edge sampled at bus edge k counts as one source tick at bus edge k+2. With no slow edges, the counter holds.
- R7: A read of the counter low word (0x20) returns the live low word and captures the live high word. A read of 0x24 returns that captured value, however many cycles have passed since the low read.
- R8: A read of the status register (0x1C) returns the pending flag in bit 0 and clears it. A wrap in the same cycle as that read leaves the flag set.
- R9: `irq` is high exactly when status bit 0 and interrupt enable bit 0 (offset 0x10, read back) are both 1.
- R10: Reads of unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | WORD_W | Write data |
| bus_re | input | 1 | Read strobe, one cycle per read; triggers read side effects |
| bus_rdata | output | WORD_W | Read data, valid in the strobe cycle |
| slow_clk | input | 1 | Asynchronous slow count source, at most one third of the bus clock rate |
| irq | output | 1 | Level interrupt for a pending wrap |

## Verification
The bench builds the block with WORD_W set to 16, which gives a 32-bit counter split into two 16-bit halves. With this width the carry from the low half into the high half happens after about 65 thousand cycles. That makes the atomic read reachable: the bench reads the low word just before the carry and the high word just after it. The field positions of control and mode still fit in a 16-bit word, so every register map position is exercised unchanged. A behavioural reference model shadows the slow-clock latency, the prescaler phase and the limit staging on every clock.

// File: rtl/itimer64_pkg.sv
package itimer64_pkg;

    localparam int PRES_W        = 4;
    localparam int CTRL_GO_BIT   = 0;
    localparam int CTRL_RST_BIT  = 8;
    localparam int MODE_LOOP_BIT = 0;
    localparam int MODE_SLOW_BIT = 3;
    localparam int MODE_DIV_LSB  = 8;

    typedef struct packed {
        logic [PRES_W-1:0] div;
        logic              slow;
        logic              loop;
    } mode_t;

    typedef enum logic [3:0] {
        SEL_NONE, SEL_CTRL, SEL_MODE, SEL_LIM_LO, SEL_LIM_HI,
        SEL_IEN, SEL_STAT, SEL_CNT_LO, SEL_CNT_HI
    } sel_t;

    function automatic sel_t decode_sel(input logic [7:0] off);
        case (off)
            8'h00:   return SEL_CTRL;
            8'h04:   return SEL_MODE;
            8'h08:   return SEL_LIM_LO;
            8'h0C:   return SEL_LIM_HI;
            8'h10:   return SEL_IEN;
            8'h1C:   return SEL_STAT;
            8'h20:   return SEL_CNT_LO;
            8'h24:   return SEL_CNT_HI;
            default: return SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/itimer64_srcsel.sv
module itimer64_srcsel
    import itimer64_pkg::*;
#(
    parameter int SYNC_N = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              slow_in,
    input  logic              use_slow,
    input  logic [PRES_W-1:0] div,
    input  logic              run,
    input  logic              clr,
    output logic              step
);

    logic [SYNC_N:0]   sync_q;
    logic [PRES_W-1:0] phase_q;
    logic              slow_tick;
    logic              src_tick;

    always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[SYNC_N-1:0], slow_in};
    end

    assign slow_tick = sync_q[SYNC_N-1] & ~sync_q[SYNC_N];
    assign src_tick  = use_slow ? slow_tick : 1'b1;

    always_ff @(posedge clk) begin
        if (rst || clr || !run)  phase_q <= '0;
        else if (src_tick)       phase_q <= (phase_q == div) ? '0 : phase_q + 1'b1;
    end

    assign step = run & src_tick & (phase_q == div);

    // R6: a synchronised edge yields a single tick
    a_r6_single_tick: assert property (@(posedge clk) disable iff (rst)
        slow_tick |=> !slow_tick);

endmodule

// File: rtl/itimer64_core.sv
module itimer64_core #(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    input  logic             loop,
    input  logic             go,
    input  logic             kill,
    input  logic [CNT_W-1:0] limit,
    input  logic             stat_rd,
    output logic [CNT_W-1:0] cnt,
    output logic             run,
    output logic             stat
);

    logic hit;
    assign hit = step && (cnt == limit);

    always_ff @(posedge clk) begin
        if (rst || kill) begin
            cnt  <= '0;
            run  <= 1'b0;
            stat <= 1'b0;
        end else begin
            if (hit) begin
                cnt <= '0;
                if (!loop) run <= 1'b0;
            end else if (step) begin
                cnt <= cnt + CNT_W'(1);
            end
            if (go) run <= 1'b1;
            if (hit)          stat <= 1'b1;
            else if (stat_rd) stat <= 1'b0;
        end
    end

    // R4: wrap returns the counter to zero
    a_r4_wrap_zero: assert property (@(posedge clk) disable iff (rst)
        hit |=> (cnt == '0));
    // R4: one-shot halts after its wrap
    a_r4_oneshot_halt: assert property (@(posedge clk) disable iff (rst)
        (hit && !loop && !go && !kill) |=> !run);
    // R8: a wrap beats a clearing read
    a_r8_set_beats_clear: assert property (@(posedge clk) disable iff (rst)
        (hit && !kill) |=> stat);
    // R2: software reset clears everything
    a_r2_kill_clears: assert property (@(posedge clk) disable iff (rst)
        kill |=> (cnt == '0 && !run && !stat));

endmodule

// File: rtl/itimer64.sv
module itimer64
    import itimer64_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int WORD_W = 32,
    parameter int SYNC_N = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [WORD_W-1:0] bus_wdata,
    input  logic              bus_re,
    output logic [WORD_W-1:0] bus_rdata,
    input  logic              slow_clk,
    output logic              irq
);

    localparam int CNT_W = 2 * WORD_W;

    sel_t              sel;
    mode_t             mode_q;
    logic [CNT_W-1:0]  limit_q;
    logic [WORD_W-1:0] stage_q;
    logic [WORD_W-1:0] hi_cap_q;
    logic              ien_q;
    logic [CNT_W-1:0]  cnt;
    logic              run, stat, step;
    logic              go, kill, stat_rd, lo_rd;

    assign sel     = decode_sel(8'(bus_addr));
    assign go      = bus_we && sel == SEL_CTRL && bus_wdata[CTRL_GO_BIT];
    assign kill    = bus_we && sel == SEL_CTRL && bus_wdata[CTRL_RST_BIT];
    assign stat_rd = bus_re && sel == SEL_STAT;
    assign lo_rd   = bus_re && sel == SEL_CNT_LO;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q   <= '0;
            limit_q  <= '1;
            stage_q  <= '0;
            hi_cap_q <= '0;
            ien_q    <= 1'b0;
        end else begin
            if (bus_we) begin
                case (sel)
                    SEL_MODE: mode_q <= '{div:  bus_wdata[MODE_DIV_LSB +: PRES_W],
                                          slow: bus_wdata[MODE_SLOW_BIT],
                                          loop: bus_wdata[MODE_LOOP_BIT]};
                    SEL_LIM_HI: stage_q <= bus_wdata;
                    SEL_LIM_LO: limit_q <= {stage_q, bus_wdata};
                    SEL_IEN:    ien_q   <= bus_wdata[0];
                    default: ;
                endcase
            end
            if (lo_rd) hi_cap_q <= cnt[CNT_W-1:WORD_W];
        end
    end

    itimer64_srcsel #(.SYNC_N(SYNC_N)) u_src (
        .clk      (clk),
        .rst      (rst),
        .slow_in  (slow_clk),
        .use_slow (mode_q.slow),
        .div      (mode_q.div),
        .run      (run),
        .clr      (kill),
        .step     (step)
    );

    itimer64_core #(.CNT_W(CNT_W)) u_core (
        .clk     (clk),
        .rst     (rst),
        .step    (step),
        .loop    (mode_q.loop),
        .go      (go),
        .kill    (kill),
        .limit   (limit_q),
        .stat_rd (stat_rd),
        .cnt     (cnt),
        .run     (run),
        .stat    (stat)
    );

    always_comb begin
        bus_rdata = '0;
        case (sel)
            SEL_MODE: begin
                bus_rdata[MODE_LOOP_BIT]               = mode_q.loop;
                bus_rdata[MODE_SLOW_BIT]               = mode_q.slow;
                bus_rdata[MODE_DIV_LSB +: PRES_W]      = mode_q.div;
            end
            SEL_LIM_LO: bus_rdata = limit_q[WORD_W-1:0];
            SEL_LIM_HI: bus_rdata = limit_q[CNT_W-1:WORD_W];
            SEL_IEN:    bus_rdata[0] = ien_q;
            SEL_STAT:   bus_rdata[0] = stat;
            SEL_CNT_LO: bus_rdata = cnt[WORD_W-1:0];
            SEL_CNT_HI: bus_rdata = hi_cap_q;
            default: ;
        endcase
    end

    assign irq = stat & ien_q;

    // R7: captured high word only moves on a low-word read
    a_r7_capture_hold: assert property (@(posedge clk) disable iff (rst)
        !lo_rd |=> $stable(hi_cap_q));

endmodule

// File: tb/itimer64_tb.sv
module itimer64_tb;

    localparam int W  = 16;
    localparam int CW = 2 * W;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [7:0]    addr = '0;
    logic          we = 1'b0;
    logic          re = 1'b0;
    logic [W-1:0]  wdata = '0;
    logic [W-1:0]  rdata;
    logic          slow = 1'b0;
    logic          irq;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    itimer64 #(.ADDR_W(8), .WORD_W(W), .SYNC_N(2)) u_dut (
        .clk(clk), .rst(rst), .bus_addr(addr), .bus_we(we), .bus_wdata(wdata),
        .bus_re(re), .bus_rdata(rdata), .slow_clk(slow), .irq(irq)
    );

    // ---------------- reference model ----------------
    logic [CW-1:0] m_cnt, m_lim;
    logic [W-1:0]  m_stage, m_hi;
    logic          m_run, m_stat, m_ien, m_loop, m_slow;
    int            m_div, m_phase;
    logic          h1, h2, h3;
    logic          t_tick, t_src, t_step, t_hit;

    always @(posedge clk) begin
        if (rst) begin
            m_cnt = '0; m_lim = '1; m_stage = '0; m_hi = '0;
            m_run = 0; m_stat = 0; m_ien = 0; m_loop = 0; m_slow = 0;
            m_div = 0; m_phase = 0; h1 = 0; h2 = 0; h3 = 0;
        end else begin
            t_tick = h2 && !h3;
            h3 = h2; h2 = h1; h1 = slow;
            t_src = m_slow ? t_tick : 1'b1;
            t_step = 1'b0;
            if (!m_run) m_phase = 0;
            else if (t_src) begin
                if (m_phase == m_div) begin m_phase = 0; t_step = 1'b1; end
                else m_phase = (m_phase + 1) % 16;
            end
            t_hit = t_step && (m_cnt == m_lim);
            if (re && addr == 8'h20) m_hi = m_cnt[CW-1:W];
            if (we && addr == 8'h00 && wdata[8]) begin
                m_cnt = '0; m_run = 0; m_stat = 0; m_phase = 0;
            end else begin
                if (t_hit) begin m_cnt = '0; if (!m_loop) m_run = 0; end
                else if (t_step) m_cnt = m_cnt + 1;
                if (we && addr == 8'h00 && wdata[0]) m_run = 1;
                if (t_hit) m_stat = 1;
                else if (re && addr == 8'h1C) m_stat = 0;
            end
            if (we) begin
                case (addr)
                    8'h04: begin m_loop = wdata[0]; m_slow = wdata[3]; m_div = int'(wdata[11:8]); end
                    8'h0C: m_stage = wdata;
                    8'h08: m_lim = {m_stage, wdata};
                    8'h10: m_ien = wdata[0];
                    default: ;
                endcase
            end
        end
    end

    function automatic logic [W-1:0] exp_rd(input logic [7:0] a);
        logic [W-1:0] v = '0;
        case (a)
            8'h04: begin v[0] = m_loop; v[3] = m_slow; v[11:8] = 4'(m_div); end
            8'h08: v = m_lim[W-1:0];
            8'h0C: v = m_lim[CW-1:W];
            8'h10: v[0] = m_ien;
            8'h1C: v[0] = m_stat;
            8'h20: v = m_cnt[W-1:0];
            8'h24: v = m_hi;
            default: v = '0;
        endcase
        return v;
    endfunction

    function automatic string tag_of(input logic [7:0] a);
        case (a)
            8'h00: return "R2";
            8'h04: return "R5";
            8'h08, 8'h0C: return "R3";
            8'h10: return "R9";
            8'h1C: return "R8";
            8'h20, 8'h24: return "R7";
            default: return "R10";
        endcase
    endfunction

    task automatic chk(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
        vectors++;
        if (got !== exp) begin
            miscompares++;
            $display("FAIL %s at %0t: got %h expected %h", tag, $time, got, exp);
        end
    endtask

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk("R9", {{(W-1){1'b0}}, irq}, {{(W-1){1'b0}}, m_stat & m_ien});
            if (re) chk(tag_of(addr), rdata, exp_rd(addr));
        end
    end

    // ---------------- stimulus ----------------
    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic bus_wr(input logic [7:0] a, input logic [W-1:0] d);
        addr = a; wdata = d; we = 1'b1;
        @(posedge clk); #1;
        we = 1'b0;
    endtask

    task automatic bus_rd(input logic [7:0] a);
        addr = a; re = 1'b1;
        @(posedge clk); #1;
        re = 1'b0;
    endtask

    task automatic rd_expect(input logic [7:0] a, input logic [W-1:0] exp, input string tag);
        addr = a; re = 1'b1;
        @(negedge clk);
        chk(tag, rdata, exp);
        @(posedge clk); #1;
        re = 1'b0;
    endtask

    task automatic poll(input int n);
        for (int i = 0; i < n; i++) begin
            if (i % 7 == 0) bus_rd(8'h1C);
            else            bus_rd(8'h20);
        end
    endtask

    task automatic finish_run;
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        idle(1);

        // R1 reset state, R10 unmapped
        rd_expect(8'h00, 16'h0000, "R1");
        rd_expect(8'h04, 16'h0000, "R1");
        rd_expect(8'h08, 16'hFFFF, "R1");
        rd_expect(8'h0C, 16'hFFFF, "R1");
        rd_expect(8'h10, 16'h0000, "R1");
        rd_expect(8'h1C, 16'h0000, "R1");
        rd_expect(8'h20, 16'h0000, "R1");
        rd_expect(8'h14, 16'h0000, "R10");
        rd_expect(8'h30, 16'h0000, "R10");

        // R4 periodic wraps, R9 interrupt
        bus_wr(8'h0C, 16'h0000);
        bus_wr(8'h08, 16'h0009);
        bus_wr(8'h10, 16'h0001);
        bus_wr(8'h04, 16'h0001);
        rd_expect(8'h10, 16'h0001, "R9");
        bus_wr(8'h00, 16'h0001);
        poll(60);

        // R2 reset beats start in one write
        bus_wr(8'h00, 16'h0101);
        idle(6);
        rd_expect(8'h20, 16'h0000, "R2");
        rd_expect(8'h1C, 16'h0000, "R2");

        // R5 prescaler p=2
        bus_wr(8'h08, 16'h0004);
        bus_wr(8'h04, 16'h0201);
        rd_expect(8'h04, 16'h0201, "R5");
        bus_wr(8'h00, 16'h0001);
        poll(70);

        // R4 one-shot halts
        bus_wr(8'h00, 16'h0100);
        bus_wr(8'h04, 16'h0000);
        bus_wr(8'h08, 16'h0005);
        bus_wr(8'h00, 16'h0001);
        idle(20);
        rd_expect(8'h20, 16'h0000, "R4");
        idle(5);
        rd_expect(8'h20, 16'h0000, "R4");
        rd_expect(8'h1C, 16'h0001, "R8");
        rd_expect(8'h1C, 16'h0000, "R8");
        bus_wr(8'h00, 16'h0001);
        poll(12);

        // R3 staged high word
        bus_wr(8'h00, 16'h0100);
        bus_wr(8'h04, 16'h0001);
        bus_wr(8'h0C, 16'h0001);
        bus_wr(8'h00, 16'h0001);
        poll(20);
        rd_expect(8'h0C, 16'h0000, "R3");
        bus_wr(8'h08, 16'h0003);
        rd_expect(8'h0C, 16'h0001, "R3");
        rd_expect(8'h08, 16'h0003, "R3");

        // R6 slow source
        bus_wr(8'h00, 16'h0100);
        bus_wr(8'h0C, 16'h0000);
        bus_wr(8'h08, 16'h0003);
        bus_wr(8'h04, 16'h0009);
        bus_wr(8'h00, 16'h0001);
        idle(10);
        rd_expect(8'h20, 16'h0000, "R6");
        for (int p = 0; p < 10; p++) begin
            slow = 1'b1;
            for (int k = 0; k < 3; k++) bus_rd(8'h20);
            slow = 1'b0;
            for (int k = 0; k < 3; k++) bus_rd(8'h20);
        end
        idle(5);
        rd_expect(8'h20, 16'h0002, "R6");

        // R7 atomic read across the half-word carry
        bus_wr(8'h00, 16'h0100);
        bus_wr(8'h04, 16'h0001);
        bus_wr(8'h0C, 16'hFFFF);
        bus_wr(8'h08, 16'hFFFF);
        bus_wr(8'h00, 16'h0001);
        idle(65520);
        rd_expect(8'h20, 16'hFFF0, "R7");
        idle(40);
        rd_expect(8'h24, 16'h0000, "R7");
        bus_rd(8'h20);
        rd_expect(8'h24, 16'h0001, "R7");

        idle(4);
        finish_run();
    end

endmodule